// File: doc/BRIEF.md
# Packet Serializer with NRZI Line Coding and Zero Insertion

This block turns a stream of packet bytes into the two logic levels of a differential serial line pair, one line symbol per bit-rate tick. A packet opens with a fixed synchronisation pattern and then carries its payload bytes, least significant bit first. A 0 bit toggles the line level and a 1 bit holds it, so a long run of 1s would leave the line without transitions. To avoid that, a 0 is inserted after every run of six 1s. The packet closes with both wires driven low for two bit times, followed by one bit time of the idle level.

Bytes arrive over a valid/ready handshake with start-of-packet and end-of-packet markers. The source presents each byte and holds it until the block takes it. The handshake completes in the tick that sends the byte's last bit. While an inserted 0 is on the line, the handshake pauses. The `bit_en` input sets the bit rate. Between ticks the line holds its value.

Top module: `usbtx_encoder`

## Requirements
- R1: A coded 0 bit changes the line level and a coded 1 bit keeps it. The level "high" means dp=1, dm=0 (the idle J symbol). The level "low" means dp=0, dm=1 (the K symbol).
- R2: dp and dm are never both 1. The end-of-packet symbol has dp=0 and dm=0.
- R3: After six consecutive coded payload 1s, one extra 0 is coded before the next payload bit.
  - The run count spans byte boundaries.
  - The inserted 0 clears the run count.
  - The inserted 0 is line-coded like any other bit.
  - If the packet's last payload bit completes a run of six, the extra 0 is still sent before the end-of-packet symbol.
- R4: `in_ready` is 1 only on a `bit_en` tick that codes bit 7 of the current byte. It is never 1 during the sync field or during an inserted 0. Each payload byte is taken exactly once.
- R5: A packet starts on a tick where `in_valid` and `in_sop` are 1 while the block is idle. It begins with the sync bits 0,0,0,0,0,0,0,1, coded from the J level, which gives the symbols K,J,K,J,K,J,K,K. No bit is inserted in the sync field, and the run count starts at zero for the payload.
- R6: After the last payload bit (and any inserted 0), the line shows the both-low symbol for exactly two bit times, then J for one bit time. After that a new packet may start.
- R7: Payload bytes are sent least significant bit first, in the order they were accepted.
- R8: While `rst_n` is 0, and right after it is released, the line is J (dp=1, dm=0) and `in_ready` is 0.
- R9: dp and dm change only in the clock cycle after a `bit_en` tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| in_valid | input | 1 | Source presents a byte |
| in_sop | input | 1 | Presented byte is the first of a packet |
| in_eop | input | 1 | Presented byte is the last of a packet |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Byte taken in this cycle |
| dp | output | 1 | Positive line level |
| dm | output | 1 | Negative line level |

## Verification
The assertions take three things for granted about the source:
- Once a packet has started, it keeps `in_valid` high with the next byte ready at every bit-7 tick until the byte marked `in_eop` has been taken.
- Each byte stays stable until its handshake.
- `in_sop` marks only the first byte of a packet.

The block does not guard against an underrun in mid-packet. The bench presents each packet's bytes back to back, with the markers derived from the byte index, and moves to the next byte only after a sampled handshake. It spaces the `bit_en` pulses four clocks apart, so every tick falls on a single isolated cycle.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_DATA,
    PH_TAIL,
    PH_SE0,
    PH_GAP
  } phase_t;

  // Line level after coding one bit: 0 flips, 1 holds.
  function automatic logic nrzi_next(input logic lvl, input logic b);
    return b ? lvl : ~lvl;
  endfunction

  // Wire pair {dp, dm} for a level, or both low when the end marker is on.
  function automatic logic [1:0] line_pair(input logic lvl, input logic se0);
    return se0 ? 2'b00 : {lvl, ~lvl};
  endfunction

endpackage

// File: rtl/usbtx_stuff.sv
module usbtx_stuff #(
  parameter int STUFF_RUN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic data_go,
  input  logic data_bit,
  input  logic stuff_go,
  output logic stuff_due
);
  localparam int CW = $clog2(STUFF_RUN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(STUFF_RUN);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clear || stuff_go) begin
      run_q <= '0;
    end else if (data_go) begin
      run_q <= data_bit ? run_q + 1'b1 : '0;
    end
  end

  assign stuff_due = (run_q == RUN_MAX);

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_MAX);  // R3
  AST_NO_DATA_WHEN_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_due |-> !data_go);  // R3

endmodule

// File: rtl/usbtx_line.sv
module usbtx_line
  import usbtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic emit_go,
  input  logic emit_bit,
  input  logic se0_go,
  input  logic j_go,
  output logic dp,
  output logic dm
);
  logic lvl_q;
  logic se0_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      se0_q <= 1'b0;
    end else if (emit_go) begin
      lvl_q <= nrzi_next(lvl_q, emit_bit);
      se0_q <= 1'b0;
    end else if (se0_go) begin
      se0_q <= 1'b1;
    end else if (j_go) begin
      lvl_q <= 1'b1;
      se0_q <= 1'b0;
    end
  end

  assign {dp, dm} = line_pair(lvl_q, se0_q);

  AST_NO_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp && dm));  // R2
  AST_ZERO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_go && !emit_bit) |=> (dp != $past(dp)));  // R1
  AST_ONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_go && emit_bit) |=> $stable(dp));  // R1
  AST_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(dp) && $stable(dm)));  // R9

endmodule

// File: rtl/usbtx_seq.sv
module usbtx_seq
  import usbtx_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SYNC_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              stuff_due,
  output logic              in_ready,
  output logic              emit_go,
  output logic              emit_bit,
  output logic              se0_go,
  output logic              j_go,
  output logic              cnt_clear,
  output logic              data_go,
  output logic              stuff_go
);
  localparam int SW = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;
  localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [SW-1:0] SYNC_LAST = SW'(SYNC_LEN - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(BYTE_W - 1);

  phase_t        ph_q;
  logic [SW-1:0] sidx_q;
  logic [BW-1:0] bidx_q;
  logic          start_go;
  logic          byte_done;

  assign start_go  = bit_en && (ph_q == PH_IDLE) && in_valid && in_sop;
  assign byte_done = data_go && (bidx_q == BIT_LAST);

  always_comb begin
    emit_go   = 1'b0;
    emit_bit  = 1'b0;
    se0_go    = 1'b0;
    j_go      = 1'b0;
    data_go   = 1'b0;
    stuff_go  = 1'b0;
    cnt_clear = start_go;
    in_ready  = 1'b0;
    if (bit_en) begin
      unique case (ph_q)
        PH_IDLE: begin
          emit_go  = start_go;
          emit_bit = (SYNC_LEN == 1);
        end
        PH_SYNC: begin
          emit_go  = 1'b1;
          emit_bit = (sidx_q == SYNC_LAST);
        end
        PH_DATA: begin
          emit_go = 1'b1;
          if (stuff_due) begin
            stuff_go = 1'b1;
          end else begin
            emit_bit = in_data[bidx_q];
            data_go  = 1'b1;
            in_ready = (bidx_q == BIT_LAST);
          end
        end
        PH_TAIL: begin
          if (stuff_due) begin
            emit_go  = 1'b1;
            stuff_go = 1'b1;
          end else begin
            se0_go = 1'b1;
          end
        end
        PH_SE0: ;
        PH_GAP: j_go = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sidx_q <= '0;
      bidx_q <= '0;
    end else if (bit_en) begin
      unique case (ph_q)
        PH_IDLE: if (start_go) begin
          ph_q   <= (SYNC_LEN == 1) ? PH_DATA : PH_SYNC;
          sidx_q <= SW'(1);
          bidx_q <= '0;
        end
        PH_SYNC: begin
          if (sidx_q == SYNC_LAST) begin
            ph_q   <= PH_DATA;
            bidx_q <= '0;
          end else begin
            sidx_q <= sidx_q + 1'b1;
          end
        end
        PH_DATA: if (data_go) begin
          bidx_q <= (bidx_q == BIT_LAST) ? '0 : bidx_q + 1'b1;
          if (byte_done && in_eop) ph_q <= PH_TAIL;
        end
        PH_TAIL: if (!stuff_due) ph_q <= PH_SE0;
        PH_SE0:  ph_q <= PH_GAP;
        PH_GAP:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  AST_NO_READY_ON_STUFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_due) |-> !in_ready);  // R4
  AST_SYNC_UNSTUFFED: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SYNC) |-> (!stuff_go && !in_ready));  // R5
  AST_SE0_SECOND_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    se0_go |=> (ph_q == PH_SE0));  // R6
  AST_GAP_AFTER_SE0: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SE0 && bit_en) |=> (ph_q == PH_GAP));  // R6

endmodule

// File: rtl/usbtx_encoder.sv
module usbtx_encoder
  import usbtx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int SYNC_LEN  = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              dp,
  output logic              dm
);
  logic emit_go, emit_bit, se0_go, j_go;
  logic cnt_clear, data_go, stuff_go, stuff_due;

  usbtx_seq #(.BYTE_W(BYTE_W), .SYNC_LEN(SYNC_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_data   (in_data),
    .stuff_due (stuff_due),
    .in_ready  (in_ready),
    .emit_go   (emit_go),
    .emit_bit  (emit_bit),
    .se0_go    (se0_go),
    .j_go      (j_go),
    .cnt_clear (cnt_clear),
    .data_go   (data_go),
    .stuff_go  (stuff_go)
  );

  usbtx_stuff #(.STUFF_RUN(STUFF_RUN)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cnt_clear),
    .data_go   (data_go),
    .data_bit  (emit_bit),
    .stuff_go  (stuff_go),
    .stuff_due (stuff_due)
  );

  usbtx_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_en),
    .emit_go  (emit_go),
    .emit_bit (emit_bit),
    .se0_go   (se0_go),
    .j_go     (j_go),
    .dp       (dp),
    .dm       (dm)
  );

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);  // R4

endmodule

// File: tb/usbtx_encoder_test.sv
module usbtx_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sop = 1'b0;
  logic       in_eop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, dp, dm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usbtx_encoder uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
    .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .in_ready(in_ready), .dp(dp), .dm(dm)
  );

  // {byte count, payload bytes (first byte lowest), expected inserted zeros}
  localparam int NPKT = 8;
  localparam logic [47:0] PKT [NPKT] = '{
    {8'd1, 32'h0000_0000, 8'd0},
    {8'd1, 32'h0000_00FF, 8'd1},
    {8'd2, 32'h0000_FFFF, 8'd2},
    {8'd1, 32'h0000_003F, 8'd1},
    {8'd1, 32'h0000_007E, 8'd1},
    {8'd3, 32'h00F0_C3A5, 8'd0},
    {8'd1, 32'h0000_00FC, 8'd1},
    {8'd2, 32'h0000_1F80, 8'd1}
  };

  localparam logic [1:0] SYM_J = 2'b10;
  localparam logic [1:0] SYM_K = 2'b01;
  localparam logic [1:0] SYM_Z = 2'b00;

  logic [1:0] cap [0:255];
  logic [1:0] exp_sym [0:255];
  int exp_n;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Reference symbol stream built from the requirements.
  task automatic build_exp(input int len, input logic [31:0] dat);
    int n;
    int run;
    logic lvl;
    logic b;
    n = 0;
    run = 0;
    lvl = 1'b1;
    for (int i = 0; i < 8; i++) begin
      b = (i == 7);
      lvl = b ? lvl : ~lvl;
      exp_sym[n] = lvl ? SYM_J : SYM_K;
      n++;
    end
    for (int i = 0; i < 8 * len; i++) begin
      if (run == 6) begin
        lvl = ~lvl;
        exp_sym[n] = lvl ? SYM_J : SYM_K;
        n++;
        run = 0;
      end
      b = dat[i];
      lvl = b ? lvl : ~lvl;
      exp_sym[n] = lvl ? SYM_J : SYM_K;
      n++;
      run = b ? run + 1 : 0;
    end
    if (run == 6) begin
      lvl = ~lvl;
      exp_sym[n] = lvl ? SYM_J : SYM_K;
      n++;
    end
    exp_sym[n] = SYM_Z; n++;
    exp_sym[n] = SYM_Z; n++;
    exp_sym[n] = SYM_J; n++;
    exp_n = n;
  endtask

  task automatic run_pkt(input int p);
    int len, stf, nsym, bi, ph, hs_cnt, unstable, seq_bad, stuffs, bits, ones;
    logic [31:0] dat, dec, mask;
    logic started, prev_tick, hs, lvl, b;
    logic [1:0] last;
    len = int'(PKT[p][47:40]);
    dat = PKT[p][39:8];
    stf = int'(PKT[p][7:0]);
    build_exp(len, dat);
    nsym = 0; bi = 0; ph = 0; hs_cnt = 0; unstable = 0;
    started = 1'b0; prev_tick = 1'b0; last = SYM_J;
    for (int it = 0; it < 4000 && nsym < exp_n; it++) begin
      @(negedge clk);
      if (prev_tick) begin
        if (started || {dp, dm} != SYM_J) begin
          started = 1'b1;
          cap[nsym] = {dp, dm};
          nsym++;
        end
        last = {dp, dm};
      end else if ({dp, dm} != last) begin
        unstable++;
      end
      bit_en = (ph == 0);
      ph = (ph + 1) % 4;
      in_valid = (bi < len);
      in_sop = (bi == 0);
      in_eop = (bi == len - 1);
      in_data = dat[8*bi +: 8];
      #1;
      hs = in_ready && bit_en;
      @(posedge clk);
      if (hs) begin
        bi++;
        hs_cnt++;
      end
      prev_tick = bit_en;
    end
    bit_en = 1'b0;
    in_valid = 1'b0;
    in_sop = 1'b0;
    in_eop = 1'b0;

    // R1 full symbol stream against the reference coder
    seq_bad = 0;
    for (int i = 0; i < exp_n; i++) if (i >= nsym || cap[i] != exp_sym[i]) seq_bad++;
    check(seq_bad == 0 && nsym == exp_n, $sformatf("R1 pkt%0d stream mismatches", p), seq_bad, 0);
    // R5 sync symbols K,J,K,J,K,J,K,K
    check(cap[0] == SYM_K && cap[1] == SYM_J && cap[2] == SYM_K && cap[3] == SYM_J &&
          cap[4] == SYM_K && cap[5] == SYM_J && cap[6] == SYM_K && cap[7] == SYM_K,
          $sformatf("R5 pkt%0d sync last", p), int'(cap[7]), int'(SYM_K));
    // R3 / R7 decode the payload from the line
    lvl = cap[7][1]; ones = 0; bits = 0; stuffs = 0; dec = '0;
    for (int i = 8; i < nsym - 3; i++) begin
      b = (cap[i][1] == lvl);
      lvl = cap[i][1];
      if (ones == 6) begin
        stuffs++;
        ones = 0;
      end else begin
        if (bits < 32) dec[bits] = b;
        bits++;
        ones = b ? ones + 1 : 0;
      end
    end
    check(stuffs == stf, $sformatf("R3 pkt%0d inserted zeros", p), stuffs, stf);
    mask = (32'h1 << (8 * len)) - 1;
    check(bits == 8 * len && (dec & mask) == dat, $sformatf("R7 pkt%0d payload", p), int'(dec), int'(dat));
    // R6 two both-low symbols then J; R2 end marker has both wires low
    check(nsym >= 3 && cap[nsym-3] == SYM_Z && cap[nsym-2] == SYM_Z && cap[nsym-1] == SYM_J,
          $sformatf("R6 R2 pkt%0d tail", p), int'(cap[nsym-2]), int'(SYM_Z));
    // R4 one handshake per byte
    check(hs_cnt == len, $sformatf("R4 pkt%0d handshakes", p), hs_cnt, len);
    // R9 no change between ticks
    check(unstable == 0, $sformatf("R9 pkt%0d changes off tick", p), unstable, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    bit_en = 1'b1;
    in_valid = 1'b1;
    in_sop = 1'b1;
    #1;
    check({dp, dm} == SYM_J && !in_ready, "R8 in reset", int'({dp, dm, in_ready}), 3'b100);
    bit_en = 1'b0;
    in_valid = 1'b0;
    in_sop = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check({dp, dm} == SYM_J && !in_ready, "R8 after release", int'({dp, dm, in_ready}), 3'b100);

    for (int p = 0; p < NPKT; p++) run_pkt(p);

    // Reset in the middle of a packet returns the line to J.
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      bit_en = (k % 4 == 0);
      in_valid = 1'b1;
      in_sop = 1'b1;
      in_data = 8'h00;
    end
    @(negedge clk);
    rst_n = 1'b0;
    bit_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check({dp, dm} == SYM_J && !in_ready, "R8 mid-packet reset", int'({dp, dm, in_ready}), 3'b100);
    bit_en = 1'b0;
    in_valid = 1'b0;
    in_sop = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check({dp, dm} == SYM_J, "R8 line after mid-packet reset", int'({dp, dm}), int'(SYM_J));

    // A packet sent right after reset still codes correctly.
    run_pkt(6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule